// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the eight-bit status byte of a serial non-volatile memory and decides, request by request, whether an array write or a status write may go ahead. A serial front end decodes opcodes and passes them in as single-cycle strobes. With the strobes it passes the byte address of an array write request and the data byte of a status write request. The block also watches the external write-protect pin, which is active low, and the busy indication of the internal write engine.

Array writes are refused in a region at the top of the array whose size depends on a two-bit lock field: nothing, the top quarter, the top half, or the whole array. Status writes pass through a lock made of a pin and a bit. When the write-protect-enable bit is 1 and the pin is low, no status write is accepted. Only a change of the pin level releases this lock.

Both kinds of write also need the write-enable latch to be set. Grants come out registered, one cycle after the request. The non-volatile bits are modelled as flops that take a parameterised value at reset.

Top module: `wp_status_guard`

## Requirements
- R1: `status_byte` bits, from bit 7 down to bit 0, are: protect-enable, flag, constant 1, constant 1, lock field high bit, lock field low bit, write-enable latch, busy. After reset it reads {WPEN_INIT, 0, 1, 1, BL_INIT, 0, 0}, which is 8'h30 with the default parameters.
- R2: When `arr_req` is high, `arr_grant` is high in the next cycle unless the address falls in a locked region. The lock field selects the region: 00 locks nothing, 01 locks 0xC00–0xFFF, 10 locks 0x800–0xFFF, 11 locks 0x000–0xFFF. The write-protect pin has no effect on array writes.
- R3: A request of either kind is refused while the write-enable latch reads 0.
- R4: A status write is refused while protect-enable is 1 and `wp_n` is low. While protect-enable is 0, status writes are accepted at either pin level. A granted status write loads data bit 7 into protect-enable and data bits 3:2 into the lock field. Data bits 6, 5, 4, 1 and 0 are ignored.
- R5: A granted status write keeps its new contents even if the pin falls while the write engine is busy afterwards. Later status writes are refused for as long as the pin stays low.
- R6: `op_wren` sets the write-enable latch. `op_wrdi` clears it, and so does the falling edge of `busy`. When a set and a clear arrive in the same cycle, the clear wins.
- R7: `op_sflag` sets the flag bit and `op_wrdi` clears it. When both arrive in the same cycle, the clear wins. Reset clears the flag.
- R8: Status bit 0 follows `busy` one cycle later. `status_byte` is valid in every cycle, including while a write is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_wren | input | 1 | Strobe: set the write-enable latch |
| op_wrdi | input | 1 | Strobe: clear the write-enable latch and the flag |
| op_sflag | input | 1 | Strobe: set the flag |
| sr_req | input | 1 | Status write request |
| sr_data | input | 8 | Data byte of the status write |
| arr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Byte address of the array write |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle running |
| status_byte | output | 8 | Status byte for readback |
| arr_grant | output | 1 | Array write accepted (pulse) |
| sr_grant | output | 1 | Status write accepted (pulse) |

## Verification
Array requests are made at each lock setting with addresses that sit exactly on both sides of every region boundary. This tells apart a correct quarter or half decode from one that is off by a bit. Status writes are tried with each combination of protect-enable and pin level, and with a pin that falls while the write engine is busy. This separates the pin-plus-bit lock from a lock driven by the pin alone or by the bit alone. Set and clear strobes are also driven in the same cycle, and together with a busy falling edge, to pin down the clear-wins priority.

// File: rtl/wp_pkg.sv
package wp_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_sel_e;

  typedef struct packed {
    logic      prot_en;
    logic      flag;
    logic      one_hi;
    logic      one_lo;
    lock_sel_e lock;
    logic      wel;
    logic      wip;
  } status_t;

  localparam int STATUS_W = $bits(status_t);

endpackage

// File: rtl/wp_range_check.sv
module wp_range_check
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  lock_sel_e          sel,
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit
);
  localparam int TOP = ADDR_W - 1;

  logic in_top_quarter;
  logic in_top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_top_quarter = &addr[TOP -: 2];
      assign in_top_half    = addr[TOP];
    end else begin : g_narrow
      assign in_top_quarter = addr[TOP];
      assign in_top_half    = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      LOCK_NONE:    hit = 1'b0;
      LOCK_QUARTER: hit = in_top_quarter;
      LOCK_HALF:    hit = in_top_half;
      LOCK_ALL:     hit = 1'b1;
      default:      hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_status_regs.sv
module wp_status_regs
  import wp_pkg::*;
#(
  parameter logic       WPEN_INIT = 1'b0,
  parameter logic [1:0] BL_INIT   = 2'b00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_wel,
  input  logic          clr_both,
  input  logic          set_flag,
  input  logic          busy,
  input  logic          load,
  input  logic [7:0]    load_data,
  output status_t       stat
);
  logic      prot_en_q;
  lock_sel_e lock_q;
  logic      wel_q;
  logic      flag_q;
  logic      busy_q;
  logic      cycle_done;
  logic      unused_load_bits;

  assign cycle_done       = busy_q & ~busy;
  assign unused_load_bits = &{1'b0, load_data[6:4], load_data[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_en_q <= WPEN_INIT;
      lock_q    <= lock_sel_e'(BL_INIT);
      wel_q     <= 1'b0;
      flag_q    <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= busy;
      if (load) begin
        prot_en_q <= load_data[7];
        lock_q    <= lock_sel_e'(load_data[3:2]);
      end
      if (clr_both || cycle_done) wel_q <= 1'b0;
      else if (set_wel)           wel_q <= 1'b1;
      if (clr_both)               flag_q <= 1'b0;
      else if (set_flag)          flag_q <= 1'b1;
    end
  end

  always_comb begin
    stat         = '0;
    stat.prot_en = prot_en_q;
    stat.flag    = flag_q;
    stat.one_hi  = 1'b1;
    stat.one_lo  = 1'b1;
    stat.lock    = lock_q;
    stat.wel     = wel_q;
    stat.wip     = busy_q;
  end

  // R6: end of a write cycle drops the write-enable latch
  assert_done_clears_wel_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !busy) |=> !stat.wel);

  // R7: clear strobe leaves the flag low
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_both |=> !stat.flag);
endmodule

// File: rtl/wp_grant_unit.sv
module wp_grant_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  status_t           stat,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              sr_req,
  input  logic              wp_n,
  output logic              sr_load,
  output logic              arr_grant,
  output logic              sr_grant
);
  logic locked_addr;
  logic sr_locked;
  logic arr_ok;

  wp_range_check #(.ADDR_W(ADDR_W)) u_range (
    .sel  (stat.lock),
    .addr (arr_addr),
    .hit  (locked_addr)
  );

  assign sr_locked = stat.prot_en & ~wp_n;
  assign sr_load   = sr_req & stat.wel & ~sr_locked;
  assign arr_ok    = arr_req & stat.wel & ~locked_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_grant <= 1'b0;
      sr_grant  <= 1'b0;
    end else begin
      arr_grant <= arr_ok;
      sr_grant  <= sr_load;
    end
  end

  // R3: no array grant without the write-enable latch
  assert_arr_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> $past(stat.wel));

  // R3: no status grant without the write-enable latch
  assert_sr_needs_wel_R3: assert property (@(posedge clk) disable iff (rst)
    sr_grant |-> $past(stat.wel));
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wp_pkg::*;
#(
  parameter int         ADDR_W    = 12,
  parameter logic       WPEN_INIT = 1'b0,
  parameter logic [1:0] BL_INIT   = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_wren,
  input  logic              op_wrdi,
  input  logic              op_sflag,
  input  logic              sr_req,
  input  logic [7:0]        sr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_n,
  input  logic              busy,
  output logic [7:0]        status_byte,
  output logic              arr_grant,
  output logic              sr_grant
);
  status_t stat;
  logic    sr_load;

  wp_status_regs #(.WPEN_INIT(WPEN_INIT), .BL_INIT(BL_INIT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .set_wel   (op_wren),
    .clr_both  (op_wrdi),
    .set_flag  (op_sflag),
    .busy      (busy),
    .load      (sr_load),
    .load_data (sr_data),
    .stat      (stat)
  );

  wp_grant_unit #(.ADDR_W(ADDR_W)) u_grant (
    .clk       (clk),
    .rst       (rst),
    .stat      (stat),
    .arr_req   (arr_req),
    .arr_addr  (arr_addr),
    .sr_req    (sr_req),
    .wp_n      (wp_n),
    .sr_load   (sr_load),
    .arr_grant (arr_grant),
    .sr_grant  (sr_grant)
  );

  assign status_byte = stat;

  // R4: a status grant never follows a cycle with bit and pin both locking
  assert_sr_lock_R4: assert property (@(posedge clk) disable iff (rst)
    sr_grant |-> !($past(status_byte[7]) && !$past(wp_n)));

  // R2: with the whole array locked no array grant appears
  assert_full_lock_R2: assert property (@(posedge clk) disable iff (rst)
    arr_grant |-> ($past(status_byte[3:2]) != 2'b11));

  // R8: busy bit follows the busy input one cycle later
  assert_wip_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (status_byte[0] == $past(busy)));

  // R1: bits 5 and 4 read as ones when checked against the port
  assert_fixed_ones_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_grant) |-> (status_byte[5:4] == 2'b11));
endmodule

// File: tb/wp_status_guard_tb.sv
`timescale 1ns/1ps
module wp_status_guard_tb;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_wren = 0, op_wrdi = 0, op_sflag = 0, sr_req = 0, arr_req = 0;
  logic [7:0] sr_data = 8'h00;
  logic [ADDR_W-1:0] arr_addr = '0;
  logic wp_n = 1'b1, busy = 1'b0;
  logic [7:0] status_byte;
  logic arr_grant, sr_grant;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wp_status_guard #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .op_wren(op_wren), .op_wrdi(op_wrdi),
    .op_sflag(op_sflag), .sr_req(sr_req), .sr_data(sr_data),
    .arr_req(arr_req), .arr_addr(arr_addr), .wp_n(wp_n), .busy(busy),
    .status_byte(status_byte), .arr_grant(arr_grant), .sr_grant(sr_grant)
  );

  // behavioural reference model
  logic       m_pe = 0, m_flag = 0, m_wel = 0, m_busy = 0;
  logic [1:0] m_bl = 0;
  logic       m_arr = 0, m_sr = 0;

  function automatic bit addr_locked(input int bl, input int a);
    if (bl == 0) return 0;
    if (bl == 1) return a >= 'hC00;
    if (bl == 2) return a >= 'h800;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pe = 0; m_flag = 0; m_wel = 0; m_busy = 0; m_bl = 0; m_arr = 0; m_sr = 0;
    end else begin
      bit done;
      done  = m_busy && !busy;
      m_arr = arr_req && m_wel && !addr_locked(int'(m_bl), int'(arr_addr));
      m_sr  = sr_req && m_wel && !(m_pe && !wp_n);
      if (m_sr) begin m_pe = sr_data[7]; m_bl = sr_data[3:2]; end
      if (op_wrdi || done) m_wel = 0; else if (op_wren) m_wel = 1;
      if (op_wrdi) m_flag = 0; else if (op_sflag) m_flag = 1;
      m_busy = busy;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1 model status byte", status_byte, {m_pe, m_flag, 2'b11, m_bl, m_wel, m_busy});
      chk("R2 model array grant", arr_grant, m_arr);
      chk("R4 model status grant", sr_grant, m_sr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic do_wren(); op_wren = 1; tick(); op_wren = 0; endtask
  task automatic do_wrdi(); op_wrdi = 1; tick(); op_wrdi = 0; endtask
  task automatic do_flag(); op_sflag = 1; tick(); op_sflag = 0; endtask
  task automatic do_arr(input int a, input int exp, input string tag);
    arr_req = 1; arr_addr = a[ADDR_W-1:0]; tick(); arr_req = 0;
    chk(tag, arr_grant, exp);
  endtask
  task automatic do_sr(input int d, input int exp, input string tag);
    sr_req = 1; sr_data = d[7:0]; tick(); sr_req = 0;
    chk(tag, sr_grant, exp);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    chk("R1 reset value", status_byte, 'h30);
    do_arr('h000, 0, "R3 array refused without latch");
    do_wren();
    chk("R6 latch set", status_byte, 'h32);
    do_arr('hFFF, 1, "R2 no lock top address");
    do_sr('h47, 1, "R4 status write accepted");
    chk("R4 ignored data bits", status_byte, 'h36);
    do_arr('hBFF, 1, "R2 quarter lock below boundary");
    do_arr('hC00, 0, "R2 quarter lock at boundary");
    do_sr('h08, 1, "R4 select half lock");
    chk("R1 half lock field", status_byte, 'h3A);
    do_arr('h7FF, 1, "R2 half lock below boundary");
    do_arr('h800, 0, "R2 half lock at boundary");
    do_sr('h0C, 1, "R4 select full lock");
    do_arr('h000, 0, "R2 full lock bottom address");
    chk("R1 full lock field", status_byte, 'h3E);
    do_flag();
    chk("R7 flag set", status_byte, 'h7E);
    do_wrdi();
    chk("R6 R7 clear strobe", status_byte, 'h3C);
    do_sr('h00, 0, "R3 status refused without latch");
    chk("R3 status unchanged", status_byte, 'h3C);
    do_wren();
    wp_n = 0;
    do_sr('h8C, 1, "R4 pin low ignored while bit clear");
    chk("R4 protect bit loaded", status_byte, 'hBE);
    do_sr('h00, 0, "R4 bit and pin lock");
    chk("R4 locked contents kept", status_byte, 'hBE);
    do_arr('h000, 0, "R2 full lock still holds");
    wp_n = 1;
    do_sr('h80, 1, "R4 pin high releases lock");
    chk("R4 lock field cleared", status_byte, 'hB2);
    busy = 1; wp_n = 0;
    tick();
    chk("R8 busy visible", status_byte, 'hB3);
    tick();
    chk("R5 contents kept under pin drop", status_byte, 'hB3);
    busy = 0;
    tick();
    chk("R6 cycle end clears latch", status_byte, 'hB0);
    do_wren();
    do_sr('h00, 0, "R5 later status write refused");
    chk("R5 protect bit stays", status_byte, 'hB2);
    do_arr('hC00, 1, "R2 pin has no effect on array");
    op_wren = 1; op_wrdi = 1; op_sflag = 1; tick();
    op_wren = 0; op_wrdi = 0; op_sflag = 0;
    chk("R6 R7 clear wins", status_byte, 'hB0);
    do_wren();
    busy = 1; tick();
    busy = 0; op_wren = 1; tick(); op_wren = 0;
    chk("R6 cycle end beats set", status_byte, 'hB0);
    repeat (3) tick();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule